// File: doc/BRIEF.md
# One-Hot Gated AND-OR Word Selector

This block picks one of eight data words and passes it to a single output word. The binary select is first turned into one enable line per input, so that at most one enable is high. Every input word is then masked by its own enable, and the masked words are merged with OR gates. No input has precedence over another: each word reaches the output only through its own enable.

The combining logic has two levels. In the first level, pairs of inputs are masked and joined by one OR. In the second level, one four-input OR merges the pair results. A parameter selects a second form of the block. In that form the masking moves into a bank of source registers. Every register whose enable is low is cleared by its synchronous reset, and the output is the plain OR of all registers. This form adds one clock of latency and removes the masking gates. A select value above the last populated input gives an all-zero output in both forms. The data width, the number of inputs and the select width are parameters.

Top module: `onehot_andor_mux`

## Requirements
- R1: With REG_SRC = 0 and a select value from 0 to 7, `dout` equals input word `sel` in the same cycle. Word k occupies bits [k*DATA_W +: DATA_W] of `din`.
- R2: For a select value from 0 to N_IN-1, the decoded enables have exactly one bit set, and that bit is the one at position `sel`.
- R3: A select value from N_IN to 2^SEL_W-1 (8 to 15 by default) gives an all-zero `dout`. In the combinational form this holds in the same cycle, and in the registered form one clock later.
- R4: The result depends only on the selected word. Any values on the other words, all ones included, leave `dout` unchanged.
- R5: With REG_SRC = 1, every source register whose enable is low is cleared at the next clock, and at most one register holds a nonzero value. After a change of select, no bits of the previously selected word remain on `dout`.
- R6: With REG_SRC = 1, `dout` after a rising edge equals the word that `sel` and `din` chose just before that edge. The latency is one clock.
- R7: With REG_SRC = 1, while `rst_n` is low at a rising edge, all source registers are cleared and `dout` is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the source registers and the checks |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | SEL_W | Binary select of the input word |
| din | input | N_IN*DATA_W | All input words packed, word k at bits [k*DATA_W +: DATA_W] |
| dout | output | DATA_W | Selected word, or zero when the select is out of range |

## Verification
The assertions assume that `sel` and `din` are stable at each rising edge. They also assume that reset is held low across the first edges, so that the source registers start from a known value. The bench changes every input only on the falling edge and keeps reset asserted for three edges. The random select covers the whole 4-bit range, so the out-of-range codes also occur. Directed passes put all-ones on the words that are not selected, so that any leak through a wrong enable shows up at the output.

// File: rtl/onehot_andor_mux_pkg.sv
// Package: shared helpers for the one-hot AND-OR selector.
// Assumes: nothing beyond standard integer arithmetic.
package onehot_andor_mux_pkg;

    // Number of pairs needed to cover n inputs (odd counts get a padded pair).
    function automatic int pair_count(input int n);
        return (n + 1) / 2;
    endfunction

endpackage

// File: rtl/sel_decoder.sv
// Module: sel_decoder
// Turns a binary select into one enable per populated input.
// Assumes: SEL_W is wide enough to address N_IN inputs. Codes at or above
// N_IN raise no enable. clk and rst_n serve only the local checks.
module sel_decoder #(
    parameter int N_IN  = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic [N_IN-1:0]  en
);

    // Compare the select with every input index.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            en[i] = (sel == SEL_W'(i));
        end
    end

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) < N_IN) |-> ($countones(en) == 1 && en[sel])); // R2

    AST_OOR_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) >= N_IN) |-> (en == '0)); // R3

endmodule

// File: rtl/pair_gate_or.sv
// Module: pair_gate_or
// First logic level: masks two input words with their enables and
// joins them with one OR, once for every pair.
// Assumes: at most one enable is high, so each pair result is either one
// word or zero.
module pair_gate_or #(
    parameter int DATA_W = 16,
    parameter int N_PAIR = 4,
    localparam int N_SLOT = 2 * N_PAIR
) (
    input  logic [N_SLOT*DATA_W-1:0] words,
    input  logic [N_SLOT-1:0]        en,
    output logic [N_PAIR*DATA_W-1:0] pair_out
);

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        // Mask both words of the pair and merge them.
        always_comb begin
            pair_out[p*DATA_W +: DATA_W] =
                (words[(2*p)*DATA_W   +: DATA_W] & {DATA_W{en[2*p]}}) |
                (words[(2*p+1)*DATA_W +: DATA_W] & {DATA_W{en[2*p+1]}});
        end
    end

endmodule

// File: rtl/or_tree.sv
// Module: or_tree
// Bitwise OR of N_WORD words. In the combinational form this is the
// four-input second level. In the registered form it merges the source
// registers directly.
// Assumes: callers give it words of which at most one is nonzero.
module or_tree #(
    parameter int DATA_W = 16,
    parameter int N_WORD = 4
) (
    input  logic [N_WORD*DATA_W-1:0] words,
    output logic [DATA_W-1:0]        merged
);

    // Fold all words into one with OR.
    always_comb begin
        merged = '0;
        for (int k = 0; k < N_WORD; k++) begin
            merged = merged | words[k*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/src_reg_bank.sv
// Module: src_reg_bank
// Source registers for the registered form. A register loads its input
// word when its enable is high. Otherwise its synchronous reset clears it.
// Assumes: the enables are one-hot or all zero. The reset is synchronous
// and active low.
module src_reg_bank #(
    parameter int DATA_W = 16,
    parameter int N_IN   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN*DATA_W-1:0] din,
    input  logic [N_IN-1:0]        en,
    output logic [N_IN*DATA_W-1:0] q
);

    logic [N_IN-1:0] live;

    for (genvar i = 0; i < N_IN; i++) begin : g_src
        // Load the selected word, clear every other register.
        always_ff @(posedge clk) begin
            if (!rst_n || !en[i]) begin
                q[i*DATA_W +: DATA_W] <= '0;
            end else begin
                q[i*DATA_W +: DATA_W] <= din[i*DATA_W +: DATA_W];
            end
        end

        // Flag a register that currently holds a nonzero value.
        always_comb live[i] = |q[i*DATA_W +: DATA_W];

        AST_UNSEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> (q[i*DATA_W +: DATA_W] == '0)); // R5
    end

    AST_SINGLE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(live) <= 1); // R5

endmodule

// File: rtl/onehot_andor_mux.sv
// Module: onehot_andor_mux
// Word-wide selector built from a decoded one-hot enable and an OR merge.
// REG_SRC = 0: two-level AND-OR logic, with no latency.
// REG_SRC = 1: the masking moves into source registers with a synchronous
// clear, and the output is their plain OR, one clock after the select.
// Assumes: sel and din are stable around the rising edge of clk.
module onehot_andor_mux #(
    parameter int DATA_W  = 16,
    parameter int N_IN    = 8,
    parameter int SEL_W   = 4,
    parameter bit REG_SRC = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SEL_W-1:0]       sel,
    input  logic [N_IN*DATA_W-1:0] din,
    output logic [DATA_W-1:0]      dout
);

    import onehot_andor_mux_pkg::*;

    localparam int N_PAIR = pair_count(N_IN);
    localparam int N_SLOT = 2 * N_PAIR;

    logic [N_IN-1:0]   en;
    logic [DATA_W-1:0] ref_word;

    sel_decoder #(.N_IN(N_IN), .SEL_W(SEL_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .en    (en)
    );

    if (REG_SRC == 1'b0) begin : g_comb
        logic [N_SLOT*DATA_W-1:0] words_pad;
        logic [N_SLOT-1:0]        en_pad;
        logic [N_PAIR*DATA_W-1:0] pair_out;

        // Pad to a whole number of pairs. A padding slot is never enabled.
        always_comb begin
            words_pad = '0;
            en_pad    = '0;
            words_pad[N_IN*DATA_W-1:0] = din;
            en_pad[N_IN-1:0]           = en;
        end

        pair_gate_or #(.DATA_W(DATA_W), .N_PAIR(N_PAIR)) u_pairs (
            .words    (words_pad),
            .en       (en_pad),
            .pair_out (pair_out)
        );

        or_tree #(.DATA_W(DATA_W), .N_WORD(N_PAIR)) u_merge (
            .words  (pair_out),
            .merged (dout)
        );
    end else begin : g_reg
        logic [N_IN*DATA_W-1:0] q;

        src_reg_bank #(.DATA_W(DATA_W), .N_IN(N_IN)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (din),
            .en    (en),
            .q     (q)
        );

        or_tree #(.DATA_W(DATA_W), .N_WORD(N_IN)) u_merge (
            .words  (q),
            .merged (dout)
        );
    end

    // Reference word for the checks below: a plain indexed pick.
    always_comb begin
        ref_word = '0;
        if (int'(sel) < N_IN) begin
            ref_word = din[int'(sel)*DATA_W +: DATA_W];
        end
    end

    if (REG_SRC == 1'b0) begin : g_chk_comb
        AST_COMB_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
            dout == ref_word); // R1
    end else begin : g_chk_reg
        AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (dout == $past(ref_word))); // R6
        AST_RESET_ZERO: assert property (@(posedge clk)
            !rst_n |=> (dout == '0)); // R7
    end

endmodule

// File: tb/test_onehot_andor_mux.sv
// Bench for onehot_andor_mux: one instance of each form, directed corner
// cases and seeded random stimulus, checked against a case-statement model.
module test_onehot_andor_mux;

    localparam int W  = 16;
    localparam int N  = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] sel;
    logic [N*W-1:0] din;
    logic [W-1:0]  dout_comb;
    logic [W-1:0]  dout_reg;

    int    n_checks = 0;
    int    n_errors = 0;
    logic [W-1:0] exp_reg;
    string reg_tag;
    logic [SW-1:0] prev_sel;

    always #10 clk = ~clk;

    onehot_andor_mux #(.DATA_W(W), .N_IN(N), .SEL_W(SW), .REG_SRC(1'b0)) i_onehot_andor_mux (
        .clk (clk), .rst_n (rst_n), .sel (sel), .din (din), .dout (dout_comb)
    );

    onehot_andor_mux #(.DATA_W(W), .N_IN(N), .SEL_W(SW), .REG_SRC(1'b1)) i_onehot_andor_mux_reg (
        .clk (clk), .rst_n (rst_n), .sel (sel), .din (din), .dout (dout_reg)
    );

    // Reference model: a plain case-statement selector.
    function automatic logic [W-1:0] ref_mux(input logic [SW-1:0] s, input logic [N*W-1:0] d);
        logic [W-1:0] r;
        case (s)
            4'd0: r = d[0*W +: W];
            4'd1: r = d[1*W +: W];
            4'd2: r = d[2*W +: W];
            4'd3: r = d[3*W +: W];
            4'd4: r = d[4*W +: W];
            4'd5: r = d[5*W +: W];
            4'd6: r = d[6*W +: W];
            4'd7: r = d[7*W +: W];
            default: r = '0;
        endcase
        return r;
    endfunction

    // Fill every word with val, except word s, which gets own.
    function automatic logic [N*W-1:0] fill(input int s, input logic [W-1:0] val,
                                            input logic [W-1:0] own);
        logic [N*W-1:0] d;
        for (int k = 0; k < N; k++) d[k*W +: W] = (k == s) ? own : val;
        return d;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One falling-edge step: check the registered form's output from the
    // last edge, apply new inputs, then check the combinational form.
    task automatic step(input logic rstv, input logic [SW-1:0] s, input logic [N*W-1:0] d,
                        input string tag);
        @(negedge clk);
        chk(reg_tag, dout_reg, exp_reg);
        rst_n = rstv;
        sel   = s;
        din   = d;
        #1;
        chk(tag, dout_comb, ref_mux(s, d));
        exp_reg = rstv ? ref_mux(s, d) : '0;
        if (!rstv)              reg_tag = "R7 reset clears registered output";
        else if (s >= 4'd8)     reg_tag = "R3 registered out-of-range select";
        else if (s != prev_sel) reg_tag = "R5 registered select change";
        else                    reg_tag = "R6 registered one-clock latency";
        prev_sel = s;
    endtask

    function automatic logic [N*W-1:0] rand_din();
        logic [N*W-1:0] d;
        for (int k = 0; k < N; k++) d[k*W +: W] = W'($urandom);
        return d;
    endfunction

    initial begin
        void'($urandom(32'd4242));
        rst_n    = 1'b0;
        sel      = '0;
        din      = '0;
        exp_reg  = '0;
        prev_sel = '0;
        reg_tag  = "R7 reset state";

        // Reset phase: data presented but the registers stay clear (R7).
        for (int k = 0; k < 3; k++) step(1'b0, SW'(k + 1), rand_din(), "R1 comb during reset");

        // R1/R4: each in-range select, other words all ones.
        for (int s = 0; s < N; s++)
            step(1'b1, SW'(s), fill(s, 16'hFFFF, 16'hA5C3 ^ 16'(s)), "R1 R4 directed select");
        // R4: selected word zero, all others ones -> output zero.
        for (int s = 0; s < N; s++)
            step(1'b1, SW'(s), fill(s, 16'hFFFF, 16'h0000), "R4 no leak from other words");
        // R2: selected word all ones, others zero, walking select.
        for (int s = N - 1; s >= 0; s--)
            step(1'b1, SW'(s), fill(s, 16'h0000, 16'hFFFF), "R2 single enable");
        // R3: every out-of-range code with all words ones.
        for (int s = N; s < 16; s++)
            step(1'b1, SW'(s), fill(0, 16'hFFFF, 16'hFFFF), "R3 out-of-range select");

        // Seeded random over the full select range.
        for (int k = 0; k < 400; k++)
            step(1'b1, SW'($urandom_range(0, 15)), rand_din(), "R1 random select");

        // Hold the same select for a few edges with new data (R6).
        for (int k = 0; k < 4; k++)
            step(1'b1, 4'd5, rand_din(), "R1 held select");

        @(negedge clk);
        chk(reg_tag, dout_reg, exp_reg);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule